// File: doc/BRIEF.md
# Microstep Translator Indexer

This block turns a step/direction command stream into per-winding current set-points for a two-phase bipolar stepper motor. It keeps an electrical angle index with 32 positions, 11.25 degrees apart, and on every rising edge of the step input moves that index forward or backward by 8, 4, 2 or 1 positions. The step size comes from a two-bit resolution select, which the block samples at the step edge. For each winding the index gives a magnitude code, a fraction of the maximum trip current that follows |cos| for winding A and |sin| for winding B, together with a polarity bit. These feed an external DAC and chopper.

On every step the block also picks a current-decay style for each winding. A winding whose magnitude drops takes the decay style from an external select input. A winding whose magnitude holds or grows is forced to slow decay. All control inputs are asynchronous to the block clock, so they pass through one shared synchroniser chain before edge detection. The asynchronous reset and the synchronous park input both hold the index at the 45-degree home point.

Top module: `ustep_indexer`

## Requirements
- R1: `res_sel_i` sets the step size, with bit 0 as the first select and bit 1 as the second: 2'b00 moves 8 positions (full step), 2'b01 moves 4 (half), 2'b10 moves 2 (quarter) and 2'b11 moves 1 (eighth).
- R2: Each accepted step moves the index θ (0..31, angle θ×11.25°) modulo 32. It moves up when `dir_i`=1 and down when `dir_i`=0, and it wraps between 31 and 0.
- R3: With MAG_W=8 the magnitude codes at quadrant offsets 0..8 are 255, 250, 236, 212, 180, 142, 98, 50, 0, which are 100, 98.08, 92.39, 83.15, 70.71, 55.56, 38.27, 19.51 and 0 percent scaled to 255. Winding A follows |cos θ| and winding B follows |sin θ|, so when one is 0 the other is 255.
- R4: After `rst_n` goes low, both magnitudes are 180 (45° home, θ=4), both polarities are 1 and both decay outputs are mixed (2'b01).
- R5: With quadrant q = θ/8, `pol_a_o` is 1 for q = 0 or 3 and 0 otherwise, and `pol_b_o` is 1 for q = 0 or 1 and 0 otherwise.
- R6: Only a low-to-high transition of `step_i` moves the index. Holding the input high or taking it low changes no output.
- R7: `res_sel_i` is used only at a step edge. Changing it without a step changes no output, and the next step uses the value present at that edge.
- R8: When a step lowers a winding's magnitude, that winding's decay output takes `decay_sel_i` (2'b00 slow, 2'b01 mixed, 2'b10 fast), and code 2'b11 is treated as mixed.
- R9: When a step leaves a winding's magnitude equal or higher, that winding's decay output is slow (2'b00).
- R10: While `park_n_i` is low the outputs hold the R4 home values and step edges are ignored. A step input already high when park is released causes no step.
- R11: An output change caused by an input transition appears on the clock edge SYNC_STAGES+1 edges after the transition (3 with defaults), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step command; rising edge advances |
| dir_i | input | 1 | Direction: 1 increases the angle |
| res_sel_i | input | 2 | Microstep resolution select |
| decay_sel_i | input | 2 | Decay style for falling magnitudes |
| park_n_i | input | 1 | Active-low synchronous hold at home |
| mag_a_o | output | MAG_W | Winding A magnitude code |
| mag_b_o | output | MAG_W | Winding B magnitude code |
| pol_a_o | output | 1 | Winding A current polarity |
| pol_b_o | output | 1 | Winding B current polarity |
| decay_a_o | output | 2 | Winding A decay style |
| decay_b_o | output | 2 | Winding B decay style |

## Verification
Each input goes through SYNC_STAGES flops, and the results register one edge later, so a step, park or select change reaches the outputs on the third rising edge after it is applied. The scenario that checks this latency samples at the falling edges after the second and the third rising edge and expects the outputs unchanged and then changed. All other checks sample at a falling edge at least four edges after the stimulus, and the inputs are held steady for four edges before each step rise, so direction, resolution and decay select are already through the synchroniser when the edge is seen.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

   localparam int IDX_W     = 5;
   localparam int POSITIONS = 1 << IDX_W;
   localparam int QUAD_PTS  = POSITIONS / 4;
   localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(QUAD_PTS / 2);

   typedef enum logic [1:0] {
      DECAY_SLOW  = 2'd0,
      DECAY_MIXED = 2'd1,
      DECAY_FAST  = 2'd2
   } decay_e;

   // hundredths of a percent of full trip current at a quadrant offset
   function automatic int unsigned quad_pct(input int unsigned off);
      case (off)
         0:       return 10000;
         1:       return 9808;
         2:       return 9239;
         3:       return 8315;
         4:       return 7071;
         5:       return 5556;
         6:       return 3827;
         7:       return 1951;
         default: return 0;
      endcase
   endfunction

   // rounded magnitude code for a given output width
   function automatic logic [15:0] mag_code(input int unsigned off, input int unsigned w);
      int unsigned full;
      full = (32'd1 << w) - 32'd1;
      return 16'((quad_pct(off) * full + 32'd5000) / 32'd10000);
   endfunction

   function automatic logic [IDX_W-1:0] stride_of(input logic [1:0] res);
      case (res)
         2'b00:   return IDX_W'(8);
         2'b01:   return IDX_W'(4);
         2'b10:   return IDX_W'(2);
         default: return IDX_W'(1);
      endcase
   endfunction

   function automatic decay_e decay_of(input logic [1:0] sel);
      case (sel)
         2'b00:   return DECAY_SLOW;
         2'b10:   return DECAY_FAST;
         default: return DECAY_MIXED;
      endcase
   endfunction

endpackage

// File: rtl/ustep_sync.sv
module ustep_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ustep_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ustep_edge.sv
module ustep_edge (
   input  logic clk_i,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/ustep_phase_lut.sv
module ustep_phase_lut #(
   parameter int MAG_W   = 8,
   parameter bit IS_SINE = 1'b0
) (
   input  logic [ustep_pkg::IDX_W-1:0] idx_i,
   output logic [MAG_W-1:0]            mag_o,
   output logic                        pol_o
);

   localparam int NPTS = ustep_pkg::QUAD_PTS + 1;

   logic [MAG_W-1:0] rom [NPTS];

   for (genvar k = 0; k < NPTS; k++) begin : g_rom
      localparam logic [MAG_W-1:0] CODE = MAG_W'(ustep_pkg::mag_code(k, MAG_W));
      assign rom[k] = CODE;
   end

   logic [1:0] quad;
   logic [2:0] off;
   logic [3:0] sel;

   assign quad = idx_i[4:3];
   assign off  = idx_i[2:0];

   // cosine counts up the table in even quadrants, sine in odd ones
   always_comb begin
      if (quad[0] ^ IS_SINE) sel = 4'd8 - {1'b0, off};
      else                   sel = {1'b0, off};
   end

   assign mag_o = rom[sel];

   if (IS_SINE) begin : g_sin_pol
      assign pol_o = ~quad[1];
   end else begin : g_cos_pol
      assign pol_o = ~(quad[1] ^ quad[0]);
   end

endmodule

// File: rtl/ustep_decay_pick.sv
module ustep_decay_pick #(
   parameter int MAG_W = 8
) (
   input  logic [MAG_W-1:0]       old_mag_i,
   input  logic [MAG_W-1:0]       new_mag_i,
   input  logic [1:0]             sel_i,
   output ustep_pkg::decay_e      decay_o
);

   always_comb begin
      if (new_mag_i < old_mag_i) decay_o = ustep_pkg::decay_of(sel_i);
      else                       decay_o = ustep_pkg::DECAY_SLOW;
   end

endmodule

// File: rtl/ustep_indexer.sv
module ustep_indexer #(
   parameter int MAG_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             dir_i,
   input  logic [1:0]       res_sel_i,
   input  logic [1:0]       decay_sel_i,
   input  logic             park_n_i,
   output logic [MAG_W-1:0] mag_a_o,
   output logic [MAG_W-1:0] mag_b_o,
   output logic             pol_a_o,
   output logic             pol_b_o,
   output logic [1:0]       decay_a_o,
   output logic [1:0]       decay_b_o
);
   import ustep_pkg::*;

   localparam int NWIND = 2;
   localparam int SYN_W = 7;
   localparam logic [MAG_W-1:0] HOME_MAG = MAG_W'(mag_code(QUAD_PTS / 2, MAG_W));

   if (MAG_W < 4 || MAG_W > 16) begin : g_bad_mag
      $error("ustep_indexer: MAG_W must lie in 4..16");
   end

   // one shared chain keeps direction and mode aligned with the step edge
   logic [SYN_W-1:0] raw_v, syn_v;
   logic             park_s, step_s, dir_s;
   logic [1:0]       res_s, dsel_s;

   assign raw_v = {park_n_i, step_i, dir_i, res_sel_i, decay_sel_i};

   ustep_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_n (rst_n),
      .d_i   (raw_v),
      .q_o   (syn_v)
   );

   assign {park_s, step_s, dir_s, res_s, dsel_s} = syn_v;

   logic step_rise, step_go;

   ustep_edge u_edge (
      .clk_i  (clk_i),
      .rst_n  (rst_n),
      .lvl_i  (step_s),
      .rise_o (step_rise)
   );

   assign step_go = step_rise & park_s;

   logic [IDX_W-1:0] idx_q, idx_nxt, stride;

   assign stride  = stride_of(res_s);
   assign idx_nxt = dir_s ? (idx_q + stride) : (idx_q - stride);

   logic [MAG_W-1:0] mag_q   [NWIND];
   logic [MAG_W-1:0] mag_nxt [NWIND];
   logic             pol_nxt [NWIND];
   logic [NWIND-1:0] pol_q;
   decay_e           dec_q   [NWIND];
   decay_e           dec_nxt [NWIND];

   for (genvar w = 0; w < NWIND; w++) begin : g_wind
      ustep_phase_lut #(.MAG_W(MAG_W), .IS_SINE(w == 1)) u_lut (
         .idx_i (idx_nxt),
         .mag_o (mag_nxt[w]),
         .pol_o (pol_nxt[w])
      );

      ustep_decay_pick #(.MAG_W(MAG_W)) u_pick (
         .old_mag_i (mag_q[w]),
         .new_mag_i (mag_nxt[w]),
         .sel_i     (dsel_s),
         .decay_o   (dec_nxt[w])
      );

      always_ff @(posedge clk_i or negedge rst_n) begin
         if (!rst_n) begin
            mag_q[w] <= HOME_MAG;
            pol_q[w] <= 1'b1;
            dec_q[w] <= DECAY_MIXED;
         end else if (!park_s) begin
            mag_q[w] <= HOME_MAG;
            pol_q[w] <= 1'b1;
            dec_q[w] <= DECAY_MIXED;
         end else if (step_go) begin
            mag_q[w] <= mag_nxt[w];
            pol_q[w] <= pol_nxt[w];
            dec_q[w] <= dec_nxt[w];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)        idx_q <= HOME_IDX;
      else if (!park_s)  idx_q <= HOME_IDX;
      else if (step_go)  idx_q <= idx_nxt;
   end

   assign mag_a_o   = mag_q[0];
   assign mag_b_o   = mag_q[1];
   assign pol_a_o   = pol_q[0];
   assign pol_b_o   = pol_q[1];
   assign decay_a_o = dec_q[0];
   assign decay_b_o = dec_q[1];

endmodule

// File: rtl/ustep_indexer_chk.sv
module ustep_indexer_chk #(
   parameter int MAG_W = 8
) (
   input logic             clk_i,
   input logic             rst_n,
   input logic             park_s,
   input logic             step_go,
   input logic [1:0]       dsel_s,
   input logic [MAG_W-1:0] mag_a,
   input logic [MAG_W-1:0] mag_b,
   input logic             pol_a,
   input logic             pol_b,
   input logic [1:0]       dec_a,
   input logic [1:0]       dec_b
);

   localparam logic [MAG_W-1:0] FULL = {MAG_W{1'b1}};
   localparam logic [MAG_W-1:0] HOME = MAG_W'(ustep_pkg::mag_code(4, MAG_W));

   // R4 / R10: park forces the home state
   a_r10_park_home: assert property (@(posedge clk_i) disable iff (!rst_n)
      !park_s |=> (mag_a == HOME && mag_b == HOME && pol_a && pol_b &&
                   dec_a == 2'd1 && dec_b == 2'd1));

   // R6: without an accepted step nothing moves
   a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
      (park_s && !step_go) |=> ($stable(mag_a) && $stable(mag_b) &&
                                $stable(pol_a) && $stable(pol_b) &&
                                $stable(dec_a) && $stable(dec_b)));

   // R9: non-falling magnitude gives slow decay
   a_r9_rise_slow_a: assert property (@(posedge clk_i) disable iff (!rst_n)
      (park_s && step_go) |=> (mag_a < $past(mag_a)) || dec_a == 2'd0);
   a_r9_rise_slow_b: assert property (@(posedge clk_i) disable iff (!rst_n)
      (park_s && step_go) |=> (mag_b < $past(mag_b)) || dec_b == 2'd0);

   // R8: falling magnitude takes the external select
   a_r8_fall_sel_a: assert property (@(posedge clk_i) disable iff (!rst_n)
      (park_s && step_go) |=> (mag_a >= $past(mag_a)) ||
         dec_a == (($past(dsel_s) == 2'd3) ? 2'd1 : $past(dsel_s)));
   a_r8_fall_sel_b: assert property (@(posedge clk_i) disable iff (!rst_n)
      (park_s && step_go) |=> (mag_b >= $past(mag_b)) ||
         dec_b == (($past(dsel_s) == 2'd3) ? 2'd1 : $past(dsel_s)));

   // R3: the windings are in quadrature
   a_r3_quad_a: assert property (@(posedge clk_i) disable iff (!rst_n)
      (mag_a == '0) |-> (mag_b == FULL));
   a_r3_quad_b: assert property (@(posedge clk_i) disable iff (!rst_n)
      (mag_b == '0) |-> (mag_a == FULL));

endmodule

bind ustep_indexer ustep_indexer_chk #(.MAG_W(MAG_W)) u_chk (
   .clk_i   (clk_i),
   .rst_n   (rst_n),
   .park_s  (park_s),
   .step_go (step_go),
   .dsel_s  (dsel_s),
   .mag_a   (mag_a_o),
   .mag_b   (mag_b_o),
   .pol_a   (pol_a_o),
   .pol_b   (pol_b_o),
   .dec_a   (decay_a_o),
   .dec_b   (decay_b_o)
);

// File: tb/ustep_indexer_bench.sv
module ustep_indexer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk_i = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 1'b0;
   logic       dir_i = 1'b1;
   logic [1:0] res_sel_i = 2'b00;
   logic [1:0] decay_sel_i = 2'b01;
   logic       park_n_i = 1'b1;
   logic [7:0] mag_a_o, mag_b_o;
   logic       pol_a_o, pol_b_o;
   logic [1:0] decay_a_o, decay_b_o;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   ustep_indexer u_ustep_indexer (
      .clk_i       (clk_i),
      .rst_n       (rst_n),
      .step_i      (step_i),
      .dir_i       (dir_i),
      .res_sel_i   (res_sel_i),
      .decay_sel_i (decay_sel_i),
      .park_n_i    (park_n_i),
      .mag_a_o     (mag_a_o),
      .mag_b_o     (mag_b_o),
      .pol_a_o     (pol_a_o),
      .pol_b_o     (pol_b_o),
      .decay_a_o   (decay_a_o),
      .decay_b_o   (decay_b_o)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   int exp_idx = 4;
   int exp_dec_a = 1;
   int exp_dec_b = 1;

   function automatic int code_at(input int off);
      case (off)
         0: return 255; 1: return 250; 2: return 236; 3: return 212;
         4: return 180; 5: return 142; 6: return 98;  7: return 50;
         default: return 0;
      endcase
   endfunction

   function automatic int ref_mag_a(input int idx);
      return ((idx / 8) % 2 == 1) ? code_at(8 - idx % 8) : code_at(idx % 8);
   endfunction

   function automatic int ref_mag_b(input int idx);
      return ((idx / 8) % 2 == 1) ? code_at(idx % 8) : code_at(8 - idx % 8);
   endfunction

   function automatic int ref_pol_a(input int idx);
      return (idx / 8 == 0 || idx / 8 == 3) ? 1 : 0;
   endfunction

   function automatic int ref_pol_b(input int idx);
      return (idx / 8 < 2) ? 1 : 0;
   endfunction

   function automatic int ref_stride(input logic [1:0] res);
      case (res)
         2'b00: return 8; 2'b01: return 4; 2'b10: return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int ref_decay(input logic [1:0] ds);
      return (ds == 2'b11) ? 1 : int'(ds);
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "mag_a", int'(mag_a_o), ref_mag_a(exp_idx));
      chk(req, "mag_b", int'(mag_b_o), ref_mag_b(exp_idx));
      chk(req, "pol_a", int'(pol_a_o), ref_pol_a(exp_idx));
      chk(req, "pol_b", int'(pol_b_o), ref_pol_b(exp_idx));
      chk(req, "decay_a", int'(decay_a_o), exp_dec_a);
      chk(req, "decay_b", int'(decay_b_o), exp_dec_b);
   endtask

   task automatic model_step(input logic d, input logic [1:0] res, input logic [1:0] ds);
      int old_a, old_b, st;
      old_a = ref_mag_a(exp_idx);
      old_b = ref_mag_b(exp_idx);
      st = ref_stride(res);
      exp_idx = d ? (exp_idx + st) % 32 : (exp_idx + 32 - st) % 32;
      exp_dec_a = (ref_mag_a(exp_idx) < old_a) ? ref_decay(ds) : 0;
      exp_dec_b = (ref_mag_b(exp_idx) < old_b) ? ref_decay(ds) : 0;
   endtask

   task automatic model_home();
      exp_idx = 4;
      exp_dec_a = 1;
      exp_dec_b = 1;
   endtask

   task automatic do_step(input logic d, input logic [1:0] res, input logic [1:0] ds,
                          input string req);
      dir_i = d; res_sel_i = res; decay_sel_i = ds;
      wait_cyc(4);
      step_i = 1'b1;
      wait_cyc(5);
      step_i = 1'b0;
      wait_cyc(4);
      model_step(d, res, ds);
      check_all(req);
   endtask

   // R4: home state after reset
   task automatic t_reset();
      model_home();
      check_all("R4");
      wait_cyc(6);
      check_all("R4");
   endtask

   // R1 / R2 / R3 / R5: full steps forward visit 135, 225, 315, 45 degrees
   task automatic t_full_fwd();
      for (int i = 0; i < 4; i++) do_step(1'b1, 2'b00, 2'b10, "R1");
      chk("R2", "full cycle back home", int'(mag_a_o), 180);
   endtask

   // R3 / R8 / R9: eighth steps through a quarter with fast decay on falls
   task automatic t_eighth_fwd();
      for (int i = 0; i < 8; i++) do_step(1'b1, 2'b11, 2'b10, "R8");
      for (int i = 0; i < 8; i++) do_step(1'b1, 2'b11, 2'b00, "R9");
      for (int i = 0; i < 4; i++) do_step(1'b1, 2'b11, 2'b01, "R3");
   endtask

   // R2 / R5 / R8: half steps backward across the 0 wrap, select code 3
   task automatic t_half_rev();
      for (int i = 0; i < 10; i++) do_step(1'b0, 2'b01, 2'b11, "R2");
      chk("R5", "pol_a after reverse", int'(pol_a_o), ref_pol_a(exp_idx));
   endtask

   // R1: quarter steps forward
   task automatic t_quarter();
      for (int i = 0; i < 6; i++) do_step(1'b1, 2'b10, 2'b01, "R1");
   endtask

   // R7: resolution change without a step has no effect, next step uses edge value
   task automatic t_mode_latch();
      int a0, b0;
      a0 = int'(mag_a_o); b0 = int'(mag_b_o);
      res_sel_i = 2'b00; wait_cyc(6);
      res_sel_i = 2'b01; wait_cyc(6);
      chk("R7", "mag_a after mode change", int'(mag_a_o), a0);
      chk("R7", "mag_b after mode change", int'(mag_b_o), b0);
      do_step(1'b1, 2'b11, 2'b10, "R7");
   endtask

   // R6: a held-high or falling step does nothing further
   task automatic t_edge_only();
      dir_i = 1'b1; res_sel_i = 2'b11; decay_sel_i = 2'b10;
      wait_cyc(4);
      step_i = 1'b1;
      wait_cyc(5);
      model_step(1'b1, 2'b11, 2'b10);
      check_all("R6");
      wait_cyc(20);
      check_all("R6");
      step_i = 1'b0;
      wait_cyc(6);
      check_all("R6");
   endtask

   // R11: result appears exactly on the third edge after the step rise
   task automatic t_latency();
      int a0;
      dir_i = 1'b1; res_sel_i = 2'b00; decay_sel_i = 2'b01;
      wait_cyc(4);
      a0 = int'(mag_a_o);
      model_step(1'b1, 2'b00, 2'b01);
      step_i = 1'b1;
      wait_cyc(2);
      chk("R11", "mag_a before due edge", int'(mag_a_o), a0);
      wait_cyc(1);
      chk("R11", "mag_a on due edge", int'(mag_a_o), ref_mag_a(exp_idx));
      check_all("R11");
      step_i = 1'b0;
      wait_cyc(5);
   endtask

   // R10: park holds home and ignores steps, including a step high at release
   task automatic t_park();
      park_n_i = 1'b0;
      wait_cyc(5);
      model_home();
      check_all("R10");
      step_i = 1'b1; wait_cyc(5); step_i = 1'b0; wait_cyc(5);
      check_all("R10");
      step_i = 1'b1; wait_cyc(5);
      park_n_i = 1'b1; wait_cyc(6);
      check_all("R10");
      step_i = 1'b0; wait_cyc(5);
      check_all("R10");
      do_step(1'b1, 2'b11, 2'b10, "R10");
   endtask

   initial begin
      wait_cyc(3);
      model_home();
      check_all("R4");
      rst_n = 1'b1;
      t_reset();
      t_full_fwd();
      t_eighth_fwd();
      t_half_rev();
      t_quarter();
      t_mode_latch();
      t_edge_only();
      t_latency();
      t_park();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_cyc(WATCHDOG);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule